// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs. A simple synchronous register port configures them. Each channel counts step ticks that come from its own prescaler. The prescaler can divide the clock by 1, 8, 64 or 512. Each channel has a period length (its timebase) and a high-time (its duty), both measured in step ticks.

All channel enables and all prescaler codes share one control word. Each channel also has its own configuration word that holds the timebase and the duty. A routing word holds one select bit per channel. Clearing a channel's select bit connects that channel's output to the modulator. Setting it forces the output low.

New timebase, duty and prescaler values are held aside and applied only at the end of the current period, so a running waveform never shows a shortened or stretched cycle. When a channel is enabled, it starts a fresh period using the values configured at that moment.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every register reads zero and all outputs are low.
- R2: Register map and readback:
  - The control word at byte address 0x000 holds the enable for channel n in bit n and the prescaler code for channel n in bits [2n+5:2n+4].
  - The configuration word for channel n sits at 0x004+4n. It holds the timebase in bits [7:0] and the duty in bits [23:16].
  - The routing word at 0x140 holds channel n's select bit at bit 4n.
  - Every implemented bit reads back as last written, and all other bits read zero.
- R3: With prescaler code 0, an enabled channel repeats a period of T clock cycles. In the first clock cycle after the write that enables it, the output is high for cycle indices i where (i mod T) < D.
- R4: Prescaler codes 1, 2 and 3 stretch every step tick to 8, 64 and 512 clock cycles. The output in cycle i is therefore high when ((i / div) mod T) < D.
- R5: A duty of 0 keeps the output constantly low. A duty equal to or above the timebase keeps it constantly high.
- R6: Timebase, duty and prescaler writes made during a period do not change the waveform until that period has ended.
- R7: A disabled channel drives its output low from the cycle after the disabling write. Re-enabling it starts a fresh period at count zero.
- R8: While a channel's routing bit is 1, its output is low. The channel's counter keeps running meanwhile.
- R9: Channels run independently, each with its own timebase, duty and prescaler.
- R10: Writes to addresses outside the map change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the modulators |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regAddr | input | ADDR_W | Byte address for writes and reads |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, valid in the same cycle |
| pwmOut | output | NUM_CH | One modulated output per channel |

## Verification
The bench uses the default build: four channels and a nine-bit address, which is just wide enough to reach the routing word. The divisor set is fixed, so pairing the 512 divisor with a two-tick timebase still covers the whole prescaler range in about two thousand cycles. Small timebases also make the mid-period reload, the re-enable restart and the routing override all visible within a few periods.

// File: rtl/pwm_quad_pkg.sv
`timescale 1ns/1ps
package pwm_quad_pkg;
  // implemented width of the timebase and duty fields
  parameter int TB_W = 8;
  // widest prescaler divide is 512, so the prescaler counter needs 9 bits
  parameter int PSC_W = 9;
  parameter int DATA_W = 32;

  // configuration handed from the register file to one channel
  typedef struct packed {
    logic             en;
    logic             modeSel;
    logic [1:0]       psc;
    logic [TB_W-1:0]  tb;
    logic [TB_W-1:0]  duty;
  } chCfg_t;

  // last prescaler count value: divide is 8 to the power of the code
  function automatic logic [PSC_W-1:0] pscLast(input logic [1:0] code);
    return PSC_W'((1 << (3 * int'(code))) - 1);
  endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
`timescale 1ns/1ps
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  output chCfg_t [NUM_CH-1:0]        chCfg
);
  localparam int CTRL_ADDR   = 'h000;
  localparam int CFG_BASE    = 'h004;
  localparam int CFG_STRIDE  = 4;
  localparam int MODE_ADDR   = 'h140;
  localparam int MODE_STRIDE = 4;
  localparam int PSC_LSB     = 4;
  localparam int TB_LSB      = 0;
  localparam int DUTY_LSB    = 16;

  logic [NUM_CH-1:0]            enQ;
  logic [NUM_CH-1:0]            modeQ;
  logic [NUM_CH-1:0][1:0]       pscQ;
  logic [NUM_CH-1:0][TB_W-1:0]  tbQ;
  logic [NUM_CH-1:0][TB_W-1:0]  dutyQ;

  logic ctrlHit, modeHit;
  assign ctrlHit = (regAddr == ADDR_W'(CTRL_ADDR));
  assign modeHit = (regAddr == ADDR_W'(MODE_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= '0;
      modeQ <= '0;
      pscQ  <= '0;
      tbQ   <= '0;
      dutyQ <= '0;
    end else if (regWrEn) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (ctrlHit) begin
          enQ[n]  <= regWrData[n];
          pscQ[n] <= regWrData[PSC_LSB + 2*n +: 2];
        end
        if (modeHit) modeQ[n] <= regWrData[MODE_STRIDE*n];
        if (regAddr == ADDR_W'(CFG_BASE + CFG_STRIDE*n)) begin
          tbQ[n]   <= regWrData[TB_LSB +: TB_W];
          dutyQ[n] <= regWrData[DUTY_LSB +: TB_W];
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (ctrlHit) begin
        regRdData[n]                  = enQ[n];
        regRdData[PSC_LSB + 2*n +: 2] = pscQ[n];
      end
      if (modeHit) regRdData[MODE_STRIDE*n] = modeQ[n];
      if (regAddr == ADDR_W'(CFG_BASE + CFG_STRIDE*n)) begin
        regRdData[TB_LSB +: TB_W]   = tbQ[n];
        regRdData[DUTY_LSB +: TB_W] = dutyQ[n];
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      chCfg[n].en      = enQ[n];
      chCfg[n].modeSel = modeQ[n];
      chCfg[n].psc     = pscQ[n];
      chCfg[n].tb      = tbQ[n];
      chCfg[n].duty    = dutyQ[n];
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
`timescale 1ns/1ps
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  chCfg_t  cfg,
  output logic    pwmOut
);
  logic              running;
  logic [TB_W-1:0]   actTb, actDuty;
  logic [1:0]        actPsc;
  logic [TB_W-1:0]   cnt;
  logic [PSC_W-1:0]  pcnt;

  // first enabled cycle works from the freshly written values
  logic [TB_W-1:0]   effTb, effDuty;
  logic [1:0]        effPsc;
  assign effTb   = running ? actTb   : cfg.tb;
  assign effDuty = running ? actDuty : cfg.duty;
  assign effPsc  = running ? actPsc  : cfg.psc;

  logic            stepTick, periodEnd;
  logic [TB_W:0]   cntInc;
  assign stepTick  = (pcnt == pscLast(effPsc));
  assign cntInc    = {1'b0, cnt} + (TB_W+1)'(1);
  assign periodEnd = stepTick && (cntInc >= {1'b0, effTb});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      actTb   <= '0;
      actDuty <= '0;
      actPsc  <= '0;
      cnt     <= '0;
      pcnt    <= '0;
    end else if (!cfg.en) begin
      running <= 1'b0;
      cnt     <= '0;
      pcnt    <= '0;
    end else begin
      running <= 1'b1;
      if (!running || periodEnd) begin
        actTb   <= cfg.tb;
        actDuty <= cfg.duty;
        actPsc  <= cfg.psc;
      end
      if (stepTick) begin
        pcnt <= '0;
        cnt  <= periodEnd ? '0 : cntInc[TB_W-1:0];
      end else begin
        pcnt <= pcnt + PSC_W'(1);
      end
    end
  end

  assign pwmOut = cfg.en && !cfg.modeSel && (cnt < effDuty);
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic [NUM_CH-1:0]   pwmOut
);
  chCfg_t [NUM_CH-1:0] chCfg;
  logic   [NUM_CH-1:0] chEn, chMode;

  pwm_quad_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .chCfg(chCfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    pwm_quad_chan chan_i (
      .clk(clk), .rstN(rstN), .cfg(chCfg[g]), .pwmOut(pwmOut[g])
    );
    assign chEn[g]   = chCfg[g].en;
    assign chMode[g] = chCfg[g].modeSel;
  end
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regRdData,
  input logic [NUM_CH-1:0]  pwmOut,
  input logic [NUM_CH-1:0]  chEn,
  input logic [NUM_CH-1:0]  chMode
);
  localparam int CTRL_TOP  = 4 + 2*NUM_CH;
  localparam int MODE_ADDR = 'h140;

  function automatic logic [31:0] modeMask();
    logic [31:0] m = '0;
    for (int n = 0; n < NUM_CH; n++) m[4*n] = 1'b1;
    return m;
  endfunction

  // R2: unused control bits read zero
  a_r2_ctrl_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (regRdData >> CTRL_TOP) == '0);

  // R2: routing word reads only its select bits
  a_r2_mode_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(MODE_ADDR)) |-> (regRdData & ~modeMask()) == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R7: disabled channel stays low
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
      !chEn[g] |-> !pwmOut[g]);
    // R8: routed-away channel stays low
    a_r8_mode_forces_low: assert property (@(posedge clk) disable iff (!rstN)
      chMode[g] |-> !pwmOut[g]);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .pwmOut(pwmOut), .chEn(chEn), .chMode(chMode)
);

// File: tb/pwm_quad_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_tb_top;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 9;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NUM_CH-1:0] pwmOut;
  logic [31:0] ctrlVal = '0;
  int nVec = 0, nMis = 0;

  always #4 clk = ~clk;

  pwm_quad #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwmOut(pwmOut)
  );

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0;
  endtask

  task automatic rdChk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    nVec++;
    if (regRdData !== exp) begin
      nMis++;
      $display("FAIL %s: addr %h read %h expected %h", tag, a, regRdData, exp);
    end
    regAddr = '0;
  endtask

  task automatic chkVal(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nMis++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setCtrl(input int ch, input bit en, input logic [1:0] psc);
    ctrlVal[ch] = en;
    ctrlVal[4 + 2*ch +: 2] = psc;
    wr('0, ctrlVal);
  endtask

  task automatic setCfg(input int ch, input logic [7:0] tb, input logic [7:0] duty);
    wr(ADDR_W'(4 + 4*ch), {8'h0, duty, 8'h0, tb});
  endtask

  // expected waveform, sample i taken i falling edges after the enable write
  task automatic pattern(input int ch, input int div, input int tb, input int duty,
                         input int n, input string tag);
    int bad = -1;
    logic got = 1'b0, exp = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (bad < 0 && pwmOut[ch] !== (((i / div) % tb) < duty)) begin
        bad = i; got = pwmOut[ch]; exp = (((i / div) % tb) < duty);
      end
      @(negedge clk);
    end
    nVec++;
    if (bad >= 0) begin
      nMis++;
      $display("FAIL %s: ch%0d sample %0d actual %b expected %b", tag, ch, bad, got, exp);
    end
  endtask

  task automatic countHigh(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut[ch] === 1'b1) hi++;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    chkVal("R1 outputs low", int'(pwmOut), 0);
    rdChk(9'h000, 32'h0, "R1 ctrl");
    rdChk(9'h004, 32'h0, "R1 cfg0");
    rdChk(9'h140, 32'h0, "R1 mode");
  endtask

  task automatic tMap();
    wr(9'h000, 32'hFFFF_FFFF);
    rdChk(9'h000, 32'h0000_0FFF, "R2 ctrl mask");
    wr(9'h000, 32'h0);
    wr(9'h010, 32'hFFFF_FFFF);
    rdChk(9'h010, 32'h00FF_00FF, "R2 cfg3 mask");
    wr(9'h140, 32'hFFFF_FFFF);
    rdChk(9'h140, 32'h0000_1111, "R2 mode mask");
    wr(9'h140, 32'h0);
    wr(9'h008, 32'h1234_5678);
    rdChk(9'h008, 32'h0034_0078, "R2 cfg1 fields");
    rdChk(9'h010, 32'h00FF_00FF, "R2 cfg3 untouched");
    wr(9'h000, 32'h0000_0E45);
    rdChk(9'h000, 32'h0000_0E45, "R2 ctrl fields");
    wr(9'h000, 32'h0);
    ctrlVal = '0;
  endtask

  task automatic tBasic();
    setCfg(0, 5, 2);
    setCtrl(0, 1, 0);
    pattern(0, 1, 5, 2, 20, "R3 tb5 d2");
    setCtrl(0, 0, 0);
    setCfg(1, 7, 4);
    setCtrl(1, 1, 0);
    pattern(1, 1, 7, 4, 21, "R3 tb7 d4");
    setCtrl(1, 0, 0);
  endtask

  task automatic tPsc();
    setCfg(0, 4, 1);
    setCtrl(0, 1, 2'd1);
    pattern(0, 8, 4, 1, 64, "R4 div8");
    setCtrl(0, 0, 0);
    setCfg(0, 2, 1);
    setCtrl(0, 1, 2'd2);
    pattern(0, 64, 2, 1, 256, "R4 div64");
    setCtrl(0, 0, 0);
    setCtrl(0, 1, 2'd3);
    pattern(0, 512, 2, 1, 2048, "R4 div512");
    setCtrl(0, 0, 0);
  endtask

  task automatic tEdges();
    setCfg(2, 4, 0);
    setCtrl(2, 1, 0);
    pattern(2, 1, 4, 0, 16, "R5 duty zero");
    setCtrl(2, 0, 0);
    setCfg(2, 4, 4);
    setCtrl(2, 1, 0);
    pattern(2, 1, 4, 4, 16, "R5 duty eq tb");
    setCtrl(2, 0, 0);
    setCfg(2, 4, 9);
    setCtrl(2, 1, 0);
    pattern(2, 1, 4, 9, 16, "R5 duty above tb");
    setCtrl(2, 0, 0);
  endtask

  task automatic tShadow();
    int bad = -1;
    setCfg(1, 8, 2);
    setCtrl(1, 1, 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    setCfg(1, 8, 6);  // written on the edge before sample 5
    for (int i = 5; i < 24; i++) begin
      if (bad < 0 && pwmOut[1] !== ((i < 8) ? ((i % 8) < 2) : ((i % 8) < 6))) bad = i;
      @(negedge clk);
    end
    chkVal("R6 reload at period end (first bad sample)", bad, -1);
    setCtrl(1, 0, 0);
  endtask

  task automatic tDisable();
    int hi;
    setCfg(0, 6, 3);
    setCtrl(0, 1, 0);
    pattern(0, 1, 6, 3, 2, "R7 before disable");
    setCtrl(0, 0, 0);
    countHigh(0, 6, hi);
    chkVal("R7 disabled output highs", hi, 0);
    setCtrl(0, 1, 0);
    pattern(0, 1, 6, 3, 12, "R7 fresh period");
    setCtrl(0, 0, 0);
  endtask

  task automatic tMode();
    int hi;
    setCfg(0, 4, 2);
    setCtrl(0, 1, 0);
    pattern(0, 1, 4, 2, 2, "R8 before routing");
    wr(9'h140, 32'h1);
    countHigh(0, 8, hi);
    chkVal("R8 routed-away highs", hi, 0);
    wr(9'h140, 32'h0);
    countHigh(0, 8, hi);
    chkVal("R8 restored highs in two periods", hi, 4);
    setCtrl(0, 0, 0);
  endtask

  task automatic tIndep();
    int bad2 = -1, bad3 = -1;
    setCfg(2, 3, 1);
    setCfg(3, 2, 1);
    ctrlVal = 32'h0;
    ctrlVal[2] = 1'b1; ctrlVal[3] = 1'b1;
    ctrlVal[10 +: 2] = 2'd1;
    wr('0, ctrlVal);
    for (int i = 0; i < 48; i++) begin
      if (bad2 < 0 && pwmOut[2] !== ((i % 3) < 1)) bad2 = i;
      if (bad3 < 0 && pwmOut[3] !== (((i / 8) % 2) < 1)) bad3 = i;
      @(negedge clk);
    end
    chkVal("R9 ch2 first bad sample", bad2, -1);
    chkVal("R9 ch3 first bad sample", bad3, -1);
    chkVal("R9 idle channels low", int'(pwmOut[1:0]), 0);
    ctrlVal = '0;
    wr('0, ctrlVal);
  endtask

  task automatic tUnmapped();
    setCfg(0, 7, 3);
    wr(9'h014, 32'hFFFF_FFFF);
    wr(9'h100, 32'hFFFF_FFFF);
    wr(9'h144, 32'hFFFF_FFFF);
    wr(9'h001, 32'hFFFF_FFFF);
    rdChk(9'h000, 32'h0, "R10 ctrl unchanged");
    rdChk(9'h004, 32'h0003_0007, "R10 cfg0 unchanged");
    rdChk(9'h140, 32'h0, "R10 mode unchanged");
    chkVal("R10 outputs low", int'(pwmOut), 0);
  endtask

  initial begin
    #(8 * 200000);
    nMis++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    @(negedge clk);
    tMap();
    tBasic();
    tPsc();
    tEdges();
    tShadow();
    tDisable();
    tMode();
    tIndep();
    tUnmapped();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end
endmodule